// File: doc/BRIEF.md
# LIN-Capable Serial Channel

This block is a full-duplex asynchronous serial channel with the extra framing needed on a LIN bus. Byte frames in both directions have one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. Every bit lasts a number of clock cycles given by a 16-bit divisor register. Each direction has a single holding register in front of its shift register, so the transmitter can accept the next byte while the current one is still on the line.

In the commanding (master) role the transmitter can send a break: the line is held low for 13 to 16 bit times, then high for a delimiter of 1 to 4 bit times, and then ordinary frames follow. In the responding (slave) role the receiver watches for a low level that lasts at least 11 bit times and reports it as a break instead of a framing error. The receiver also flags parity errors, framing errors and overruns, each with its own flag.

Software reaches the channel through a small byte-wide register port. Address 0 is the data register, 1 is control, 2 and 3 are the low and high divisor bytes, 4 is status and 5 is the command register. Reads are combinational. Writes and read side effects happen on the rising clock edge.

Top module: `lin_uart`

## Requirements
- R1: While idle the line `txd` is high. A byte frame is a low start bit, data bits 0..7 in that order, an optional parity bit and a high stop bit. Each bit lasts exactly DIV clock cycles, where DIV is {register 3, register 2}.
- R2: Control bit 0 enables parity. Control bit 1 chooses its sense: with bit 1 = 0 the eight data bits and the parity bit together hold an even number of ones, and with bit 1 = 1 an odd number.
- R3: A write to register 0 fills the transmit holding register. Status bit 0 (holding register empty) returns to 1 on the clock edge where the byte moves into the shift register. A byte already waiting when a stop bit ends starts on the very next cycle, with no idle gap.
- R4: With control bit 2 = 1 (master), writing 1 to bit 0 of register 5 sends a break. The break is low for 13 + control[4:3] bit times, then high for 1 + control[6:5] bit times. A pending break goes out before a pending byte.
- R5: With control bit 2 = 0 (slave), the break command is ignored: the line stays high and status bit 6 (transmitter busy) stays 0.
- R6: A correctly received byte is stored and sets status bit 1. Reading register 0 returns the byte and clears status bit 1.
- R7: A received parity bit that does not match the configured sense sets status bit 2. The byte is still stored.
- R8: A stop bit sampled low sets status bit 3 once the line returns high. The byte is discarded.
- R9: A byte that completes while status bit 1 is still set sets status bit 4. The new byte is discarded and the stored byte is kept.
- R10: In the slave role, a low line lasting at least 11 bit times sets status bit 5 and sets neither status bit 3 nor status bit 1. In the master role the same low sets status bit 3 and not bit 5.
- R11: After reset, status reads 0x01 and `txd` is high. Writing 1s to register 4 clears the matching flags among bits 2..5.
- R12: Transmission and reception run at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on data register) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The hardest case to reach is telling a slave-role break apart from a framing error. The receiver has already sampled a low stop bit and is parked waiting for the line to rise. The outcome depends only on whether the low lasted long enough by the moment the line returns high. The bench drives `rxd` low for 13 bit times, once in each role, and then looks at the flag pair. Back-to-back transmission is covered by writing a second byte while the first is still shifting. A break command is also issued while a byte is pending, so that a per-cycle model of the line checks both the absence of a gap and the break-before-byte order.

// File: rtl/lin_uart_pkg.sv
package lin_uart_pkg;
  localparam int DW = 8;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_DIVL = 3'd2;
  localparam logic [2:0] A_DIVH = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_CMD  = 3'd5;

  typedef enum logic [2:0] {
    TX_IDLE, TX_BRK, TX_DELIM, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_st_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD_LOW
  } rx_st_e;

  typedef struct packed {
    logic [1:0] dlm_sel;
    logic [1:0] brk_sel;
    logic       master;
    logic       par_odd;
    logic       par_en;
  } cfg_t;

  // parity bit that completes the requested sense over the data byte
  function automatic logic par_bit(input logic [DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  function automatic logic [4:0] brk_len(input logic [1:0] sel);
    return 5'd13 + {3'b000, sel};
  endfunction

  function automatic logic [4:0] dlm_len(input logic [1:0] sel);
    return 5'd1 + {3'b000, sel};
  endfunction
endpackage

// File: rtl/lin_uart_sync.sv
module lin_uart_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx
  import lin_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic [1:0]       brk_sel,
  input  logic [1:0]       dlm_sel,
  input  logic             hold_full,
  input  logic [DW-1:0]    hold_data,
  input  logic             brk_req,
  output logic             load,
  output logic             brk_take,
  output logic             txd,
  output logic             busy
);
  tx_st_e           st;
  logic [DIV_W-1:0] cnt;
  logic [4:0]       nbits;
  logic [DW-1:0]    sh;
  logic             par_q;
  logic             bit_end;
  logic             pick;

  assign bit_end = (cnt == '0);
  assign busy    = (st != TX_IDLE);

  // a new item may start when idle or when the last bit of a frame/delimiter ends
  assign pick = (st == TX_IDLE) ||
                (bit_end && (st == TX_STOP)) ||
                (bit_end && (st == TX_DELIM) && (nbits == 5'd0));

  assign brk_take = pick && brk_req;
  assign load     = pick && !brk_req && hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= TX_IDLE;
      cnt   <= '0;
      nbits <= '0;
      sh    <= '0;
      par_q <= 1'b0;
      txd   <= 1'b1;
    end else if (brk_take) begin
      st    <= TX_BRK;
      txd   <= 1'b0;
      cnt   <= div - 1'b1;
      nbits <= brk_len(brk_sel) - 5'd1;
    end else if (load) begin
      st    <= TX_START;
      txd   <= 1'b0;
      cnt   <= div - 1'b1;
      sh    <= hold_data;
      par_q <= par_bit(hold_data, par_odd);
    end else if (pick) begin
      st  <= TX_IDLE;
      txd <= 1'b1;
    end else if (st != TX_IDLE) begin
      if (!bit_end) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= div - 1'b1;
        case (st)
          TX_BRK: begin
            if (nbits != 5'd0) begin
              nbits <= nbits - 5'd1;
            end else begin
              st    <= TX_DELIM;
              txd   <= 1'b1;
              nbits <= dlm_len(dlm_sel) - 5'd1;
            end
          end
          TX_DELIM: nbits <= nbits - 5'd1;
          TX_START: begin
            st    <= TX_DATA;
            txd   <= sh[0];
            sh    <= sh >> 1;
            nbits <= 5'(DW - 1);
          end
          TX_DATA: begin
            if (nbits != 5'd0) begin
              txd   <= sh[0];
              sh    <= sh >> 1;
              nbits <= nbits - 5'd1;
            end else if (par_en) begin
              st  <= TX_PAR;
              txd <= par_q;
            end else begin
              st  <= TX_STOP;
              txd <= 1'b1;
            end
          end
          TX_PAR: begin
            st  <= TX_STOP;
            txd <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lin_uart_rx.sv
module lin_uart_rx
  import lin_uart_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int BRK_BITS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd_s,
  input  logic [DIV_W-1:0] div,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             master,
  output logic             done,
  output logic [DW-1:0]    data,
  output logic             par_bad,
  output logic             ferr_evt,
  output logic             brk_evt
);
  localparam int LR_W = DIV_W + 5;

  function automatic logic [LR_W-1:0] brk_thresh(input logic [DIV_W-1:0] d);
    return LR_W'(BRK_BITS) * LR_W'(d);
  endfunction

  rx_st_e           st;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       nb;
  logic [DW-1:0]    sh;
  logic             pbit;
  logic [LR_W-1:0]  low_run;
  logic [LR_W-1:0]  thr;
  logic             long_low;
  logic             brk_hit;
  logic             tick;

  assign thr      = brk_thresh(div);
  assign long_low = (low_run == thr);
  assign brk_hit  = !rxd_s && (low_run == thr - 1'b1);
  assign brk_evt  = brk_hit && !master;
  assign tick     = (cnt == '0);

  assign done     = (st == RX_STOP) && tick && rxd_s;
  assign data     = sh;
  assign par_bad  = par_en && (pbit != par_bit(sh, par_odd));
  assign ferr_evt = (st == RX_HOLD_LOW) && rxd_s && !(long_low && !master);

  // saturating count of consecutive low cycles on the line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           low_run <= '0;
    else if (rxd_s)       low_run <= '0;
    else if (!long_low)   low_run <= low_run + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      nb   <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else begin
      case (st)
        RX_IDLE: if (!rxd_s) begin
          st  <= RX_START;
          cnt <= div >> 1;
        end
        RX_START: begin
          if (!tick) cnt <= cnt - 1'b1;
          else if (!rxd_s) begin
            st  <= RX_DATA;
            cnt <= div - 1'b1;
            nb  <= 3'(DW - 1);
          end else st <= RX_IDLE;
        end
        RX_DATA: begin
          if (!tick) cnt <= cnt - 1'b1;
          else begin
            sh  <= {rxd_s, sh[DW-1:1]};
            cnt <= div - 1'b1;
            if (nb != 3'd0) nb <= nb - 3'd1;
            else            st <= par_en ? RX_PAR : RX_STOP;
          end
        end
        RX_PAR: begin
          if (!tick) cnt <= cnt - 1'b1;
          else begin
            pbit <= rxd_s;
            cnt  <= div - 1'b1;
            st   <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (!tick)      cnt <= cnt - 1'b1;
          else if (rxd_s) st  <= RX_IDLE;
          else            st  <= RX_HOLD_LOW;
        end
        RX_HOLD_LOW: if (rxd_s) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lin_uart.sv
module lin_uart
  import lin_uart_pkg::*;
#(
  parameter int          DIV_W        = 16,
  parameter logic [15:0] DIV_RST      = 16'd16,
  parameter int          SYNC_STAGES  = 2,
  parameter int          BRK_DET_BITS = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd
);
  cfg_t             cfg_q;
  logic [DIV_W-1:0] div_q;
  logic [DW-1:0]    hold_q;
  logic             hold_full;
  logic             brk_pend;
  logic [DW-1:0]    rx_buf;
  logic             rx_full;
  logic             perr_q, ferr_q, ovr_q, brkf_q;

  logic data_wr, rd_data, stat_wr, brk_cmd;
  logic tx_load, brk_take, tx_busy;
  logic rxd_s, rx_done, par_bad, ferr_evt, brk_evt, rx_keep;
  logic [DW-1:0] rx_data;
  logic [7:0] status;

  assign data_wr = wr_en && (addr == A_DATA);
  assign rd_data = rd_en && (addr == A_DATA);
  assign stat_wr = wr_en && (addr == A_STAT);
  assign brk_cmd = wr_en && (addr == A_CMD) && wdata[0];
  assign rx_keep = rx_full && !rd_data;

  lin_uart_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  lin_uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(div_q),
    .par_en(cfg_q.par_en), .par_odd(cfg_q.par_odd),
    .brk_sel(cfg_q.brk_sel), .dlm_sel(cfg_q.dlm_sel),
    .hold_full(hold_full), .hold_data(hold_q), .brk_req(brk_pend),
    .load(tx_load), .brk_take(brk_take), .txd(txd), .busy(tx_busy)
  );

  lin_uart_rx #(.DIV_W(DIV_W), .BRK_BITS(BRK_DET_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd_s(rxd_s), .div(div_q),
    .par_en(cfg_q.par_en), .par_odd(cfg_q.par_odd), .master(cfg_q.master),
    .done(rx_done), .data(rx_data), .par_bad(par_bad),
    .ferr_evt(ferr_evt), .brk_evt(brk_evt)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= DIV_W'(DIV_RST);
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          cfg_q.par_en  <= wdata[0];
          cfg_q.par_odd <= wdata[1];
          cfg_q.master  <= wdata[2];
          cfg_q.brk_sel <= wdata[4:3];
          cfg_q.dlm_sel <= wdata[6:5];
        end
        A_DIVL: div_q[7:0]       <= wdata;
        A_DIVH: div_q[DIV_W-1:8] <= wdata[DIV_W-9:0];
        default: ;
      endcase
    end
  end

  // transmit holding register and break request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      brk_pend  <= 1'b0;
    end else begin
      if (data_wr) begin
        hold_q    <= wdata;
        hold_full <= 1'b1;
      end else if (tx_load) begin
        hold_full <= 1'b0;
      end
      if (brk_cmd && cfg_q.master) brk_pend <= 1'b1;
      else if (brk_take)           brk_pend <= 1'b0;
    end
  end

  // receive holding register and error flags (set wins over clear)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
      brkf_q  <= 1'b0;
    end else begin
      if (rx_done && !rx_keep) begin
        rx_buf  <= rx_data;
        rx_full <= 1'b1;
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end
      if (rx_done && !rx_keep && par_bad) perr_q <= 1'b1;
      else if (stat_wr && wdata[2])       perr_q <= 1'b0;
      if (ferr_evt)                       ferr_q <= 1'b1;
      else if (stat_wr && wdata[3])       ferr_q <= 1'b0;
      if (rx_done && rx_keep)             ovr_q  <= 1'b1;
      else if (stat_wr && wdata[4])       ovr_q  <= 1'b0;
      if (brk_evt)                        brkf_q <= 1'b1;
      else if (stat_wr && wdata[5])       brkf_q <= 1'b0;
    end
  end

  assign status = {1'b0, tx_busy, brkf_q, ovr_q, ferr_q, perr_q, rx_full, !hold_full};

  always_comb begin
    case (addr)
      A_DATA:  rdata = rx_buf;
      A_CTRL:  rdata = {1'b0, cfg_q.dlm_sel, cfg_q.brk_sel, cfg_q.master,
                        cfg_q.par_odd, cfg_q.par_en};
      A_DIVL:  rdata = div_q[7:0];
      A_DIVH:  rdata = 8'(div_q[DIV_W-1:8]);
      A_STAT:  rdata = status;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/lin_uart_chk.sv
module lin_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic tx_busy,
  input logic tx_load,
  input logic data_wr,
  input logic hold_full,
  input logic rx_done,
  input logic rx_full,
  input logic rd_data,
  input logic ovr_q,
  input logic brk_evt,
  input logic ferr_evt,
  input logic brkf_q,
  input logic brk_pend,
  input logic master
);
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  a_r3_hold_empty_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !data_wr) |=> !hold_full);

  a_r9_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full && !rd_data) |=> ovr_q);

  a_r10_break_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brkf_q);

  a_r10_break_not_framing: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |-> !ferr_evt);

  a_r5_break_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_pend) |-> $past(master));
endmodule

bind lin_uart lin_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .tx_load(tx_load),
  .data_wr(data_wr), .hold_full(hold_full), .rx_done(rx_done),
  .rx_full(rx_full), .rd_data(rd_data), .ovr_q(ovr_q), .brk_evt(brk_evt),
  .ferr_evt(ferr_evt), .brkf_q(brkf_q), .brk_pend(brk_pend),
  .master(cfg_q.master)
);

// File: tb/lin_uart_tb_top.sv
`timescale 1ns/1ps
module lin_uart_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rxd = 1'b1;
  logic       txd;

  int n_tests = 0;
  int n_fail  = 0;
  int bitlen  = 8;
  string tx_tag = "R11";

  always #2.5 clk = ~clk;

  lin_uart dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd)
  );

  // behavioural model of the transmit line: one queue entry per clock cycle
  bit       lq[$];
  bit       m_txd = 1'b1;
  bit       m_hfull = 1'b0, m_brk = 1'b0;
  bit [7:0] m_hold = 8'h00;
  bit       m_pen = 1'b0, m_podd = 1'b0, m_master = 1'b0;
  int       m_bsel = 0, m_dsel = 0;
  int       m_div = 16;

  task automatic push_level(input bit lvl, input int nbit);
    for (int i = 0; i < nbit * m_div; i++) lq.push_back(lvl);
  endtask

  task automatic push_frame(input bit [7:0] d);
    push_level(1'b0, 1);
    for (int i = 0; i < 8; i++) push_level(d[i], 1);
    if (m_pen) push_level((^d) ^ m_podd, 1);
    push_level(1'b1, 1);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      lq.delete();
      m_txd = 1'b1; m_hfull = 1'b0; m_brk = 1'b0;
      m_pen = 1'b0; m_podd = 1'b0; m_master = 1'b0;
      m_bsel = 0; m_dsel = 0; m_div = 16;
    end else begin
      if (lq.size() == 0) begin
        if (m_brk) begin
          push_level(1'b0, 13 + m_bsel);
          push_level(1'b1, 1 + m_dsel);
          m_brk = 1'b0;
        end else if (m_hfull) begin
          push_frame(m_hold);
          m_hfull = 1'b0;
        end
      end
      if (lq.size() > 0) m_txd = lq.pop_front();
      else               m_txd = 1'b1;
      if (wr_en) begin
        case (addr)
          3'd0: begin m_hold = wdata; m_hfull = 1'b1; end
          3'd1: begin
            m_pen = wdata[0]; m_podd = wdata[1]; m_master = wdata[2];
            m_bsel = int'(wdata[4:3]); m_dsel = int'(wdata[6:5]);
          end
          3'd2: m_div = (m_div & 32'hFF00) | int'(wdata);
          3'd3: m_div = (m_div & 32'h00FF) | (int'(wdata) << 8);
          3'd5: if (wdata[0] && m_master) m_brk = 1'b1;
          default: ;
        endcase
      end
    end
  end

  // line compared against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (txd !== m_txd) begin
        n_fail++;
        $display("FAIL %s tx line at %0t: actual %0b expected %0b", tx_tag, $time, txd, m_txd);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic hold_rx(input logic lvl, input int nbit);
    rxd = lvl;
    repeat (nbit * bitlen) @(negedge clk);
  endtask

  // par_mode: 0 none, 1 correct even, 2 wrong even; stop_lvl is the stop bit level
  task automatic send_rx(input logic [7:0] d, input int par_mode, input logic stop_lvl);
    @(negedge clk);
    hold_rx(1'b0, 1);
    for (int i = 0; i < 8; i++) hold_rx(d[i], 1);
    if (par_mode == 1) hold_rx(^d, 1);
    if (par_mode == 2) hold_rx(~(^d), 1);
    hold_rx(stop_lvl, 1);
    hold_rx(1'b1, 2);
  endtask

  task automatic wait_tx_idle();
    while (lq.size() != 0 || m_hfull || m_brk) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd4, v);
    check("R11 reset status", v, 8'h01);
    check("R11 reset line", txd, 1'b1);

    wr(3'd2, 8'd8);
    wr(3'd3, 8'd0);
    bitlen = 8;
    wr(3'd1, 8'h04);
    rd(3'd2, v);
    check("R1 divisor readback", v, 8'd8);

    // R1/R3: back-to-back bytes, second one waits in the holding register
    tx_tag = "R3";
    wr(3'd0, 8'hA5);
    wr(3'd0, 8'h3C);
    rd(3'd4, v);
    check("R3 holding full while first byte shifts", v, 8'h40);
    wait_tx_idle();
    rd(3'd4, v);
    check("R3 holding empty after both sent", v, 8'h01);

    // R2: even then odd parity
    tx_tag = "R2";
    wr(3'd1, 8'h05);
    wr(3'd0, 8'h07);
    wait_tx_idle();
    wr(3'd1, 8'h07);
    wr(3'd0, 8'h0F);
    wait_tx_idle();

    // R4: break (16 low, 3 high) queued behind a pending byte takes priority
    tx_tag = "R4";
    wr(3'd1, 8'h5C);
    wr(3'd0, 8'h11);
    wr(3'd0, 8'h55);
    wr(3'd5, 8'h01);
    wait_tx_idle();
    rd(3'd4, v);
    check("R4 transmitter idle after break and byte", v, 8'h01);

    // R5: slave role ignores the break command
    tx_tag = "R5";
    wr(3'd1, 8'h00);
    wr(3'd5, 8'h01);
    repeat (20 * 8) @(negedge clk);
    rd(3'd4, v);
    check("R5 not busy after ignored break", v, 8'h01);
    check("R5 line high", txd, 1'b1);

    // R6: plain reception
    tx_tag = "R6";
    send_rx(8'h3C, 0, 1'b1);
    rd(3'd4, v);
    check("R6 rx full", v, 8'h03);
    rd(3'd0, v);
    check("R6 rx data", v, 8'h3C);
    rd(3'd4, v);
    check("R6 rx full cleared by read", v, 8'h01);

    // R7: parity error keeps the byte
    wr(3'd1, 8'h01);
    send_rx(8'h81, 2, 1'b1);
    rd(3'd4, v);
    check("R7 parity error flag", v, 8'h07);
    rd(3'd0, v);
    check("R7 byte kept", v, 8'h81);
    wr(3'd4, 8'h3C);
    rd(3'd4, v);
    check("R11 flags cleared", v, 8'h01);
    send_rx(8'h07, 1, 1'b1);
    rd(3'd4, v);
    check("R7 good parity no flag", v, 8'h03);
    rd(3'd0, v);
    check("R7 good parity data", v, 8'h07);

    // R8: framing error discards the byte
    wr(3'd1, 8'h00);
    send_rx(8'h12, 0, 1'b0);
    rd(3'd4, v);
    check("R8 framing flag, no byte", v, 8'h09);
    wr(3'd4, 8'h08);

    // R9: overrun keeps the first byte
    send_rx(8'h21, 0, 1'b1);
    send_rx(8'h42, 0, 1'b1);
    rd(3'd4, v);
    check("R9 overrun flag", v, 8'h13);
    rd(3'd0, v);
    check("R9 first byte kept", v, 8'h21);
    wr(3'd4, 8'h10);

    // R10: long low in slave role is a break, in master role a framing error
    @(negedge clk);
    hold_rx(1'b0, 13);
    hold_rx(1'b1, 3);
    rd(3'd4, v);
    check("R10 slave break flag only", v, 8'h21);
    wr(3'd4, 8'h20);
    wr(3'd1, 8'h04);
    @(negedge clk);
    hold_rx(1'b0, 13);
    hold_rx(1'b1, 3);
    rd(3'd4, v);
    check("R10 master long low is framing", v, 8'h09);
    wr(3'd4, 8'h3C);

    // R12: send and receive at once
    tx_tag = "R12";
    fork
      wr(3'd0, 8'h96);
      send_rx(8'h69, 0, 1'b1);
    join
    wait_tx_idle();
    rd(3'd4, v);
    check("R12 rx during tx", v, 8'h03);
    rd(3'd0, v);
    check("R12 rx data during tx", v, 8'h69);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule